// File: doc/BRIEF.md
# Interleaved Luma Deblocking Edge Scheduler

This block is the control sequencer for deblocking one 16x16 luma macroblock held as a grid of 4x4 blocks. It does not filter all vertical edges of the macroblock first and all horizontal edges afterwards. Instead it works through the current blocks in raster order. It filters vertical edges as their right-hand block arrives, and filters the top edge of each block as soon as that block has been turned to column order. As a result, only one row of four blocks waits in on-chip memory at any time.

Each cycle the sequencer issues control for a datapath that moves one 32-bit word (four pixels) per cycle. The controls are: fetch requests tagged with a block number, on-chip memory writes, the shift into the transpose buffer, filter enable, filter direction, filter operand source, and output enables tagged with a block number. It also reports the block being worked on, the word within the block, a running edge number and a cycle count. A one-cycle completion pulse follows the last output word.

Blocks are numbered 1 to 24 on a 5x5 grid with the top-left corner missing. Blocks 1-4 form the row above the macroblock. Blocks 5, 10, 15 and 20 form the column to its left. The current blocks are (r+1)*5+c+1 for block row r and block column c, both counted from 0. The sequence is built from these states: IDLE, PRELOAD (16 cycles), LEFT (4), VEDGE (4 per edge), XPOSE (4 per block), HEDGE (4 per edge), FLUSH (16), DONE (1). Transitions: IDLE->PRELOAD on start. PRELOAD->LEFT. LEFT->VEDGE. VEDGE->VEDGE after column 0, otherwise VEDGE->XPOSE. XPOSE->HEDGE. HEDGE->VEDGE for columns 0-1, HEDGE->XPOSE after column 2, HEDGE->VEDGE of the next row after column 3, and HEDGE->FLUSH after the last row. FLUSH->DONE. DONE->IDLE.

Top module: `dbk_edge_sched`

## Requirements
- R1: After reset, busy, done, fetch_req, sram_wr, xpose_shift, filt_en and out_en are all 0.
- R2: A start pulse seen in IDLE begins 16 preload cycles. In each of them fetch_req and sram_wr are 1, fetch_blk steps through blocks 1,2,3,4 with four words each, and word_idx counts 0..3 within each block.
- R3: The next 4 cycles fetch left neighbour block 5 (fetch_blk=5), with filt_en 0.
- R4: Within each block row, taken top to bottom, edges are filtered in this order: vertical at column 0, vertical at column 1, horizontal at column 0, vertical at column 2, horizontal at column 1, vertical at column 3, horizontal at column 2, horizontal at column 3. blk_idx names the current block (r+1)*5+c+1.
- R5: Every edge holds filt_en for 4 cycles. For a vertical edge, filt_dir=0 and src_sel=1 (shift register with input word), and the current block is fetched. For a horizontal edge, filt_dir=1 and src_sel=2 (memory with transpose buffer), sram_wr=1, and out_en=1 with out_blk = the block above.
- R6: Each current block is shifted into the transpose buffer for 4 cycles (xpose_shift) just before its horizontal edge. In the last column of rows 0-2, those same cycles also fetch the next row's left neighbour (10, 15, 20), so 12 cycles overlap.
- R7: The final 16 working cycles output blocks 21..24 (out_en=1, four words each), with filt_en 0.
- R8: done is 1 for exactly one cycle, right after the 228th working cycle. At that point cycle_cnt reads 228.
- R9: start is ignored while busy: a run with extra start pulses has the same timing and gives one done.
- R10: edge_num is 0 on the first edge, goes up by one per edge, and ends at 31.
- R11: During vertical edges of column 0, out_en=1 with out_blk equal to that row's left neighbour (5, 10, 15, 20).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a macroblock (used only in IDLE) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| fetch_req | output | 1 | Request one input word |
| fetch_blk | output | 5 | Block number of the fetched word |
| sram_wr | output | 1 | Write a word to on-chip memory |
| xpose_shift | output | 1 | Shift a word from shift register to transpose buffer |
| filt_en | output | 1 | Filter active this cycle |
| filt_dir | output | 1 | 0 vertical edge, 1 horizontal edge |
| src_sel | output | 2 | 0 none, 1 shift register and input, 2 memory and transpose |
| edge_num | output | 5 | Running edge number |
| blk_idx | output | 5 | Block being worked on |
| word_idx | output | 2 | Word within the block |
| out_en | output | 1 | Output word valid |
| out_blk | output | 5 | Block number of the output word |
| cycle_cnt | output | 8 | Working cycles elapsed |

## Verification
Two functions share the same cycles. In the last column of each upper block row, the shift of the current block into the transpose buffer coincides with the fetch of the next row's left neighbour. The bench runs whole macroblocks and counts the cycles where xpose_shift and fetch_req are both high. It expects twelve such cycles, with fetch_blk naming 10, 15 and 20 in turn, while the edge order and the total of 228 working cycles stay exactly as they are without the overlap.

// File: rtl/dbk_sched_pkg.sv
package dbk_sched_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_PRELOAD, ST_LEFT, ST_VEDGE,
        ST_XPOSE, ST_HEDGE, ST_FLUSH, ST_DONE
    } sched_state_t;

    typedef enum logic [1:0] {
        SRC_NONE     = 2'd0,
        SRC_SHIFT_IN = 2'd1,
        SRC_SRAM_XP  = 2'd2
    } src_sel_t;
endpackage

// File: rtl/dbk_word_ctr.sv
module dbk_word_ctr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         en,
    input  logic [W-1:0] limit,
    output logic [W-1:0] cnt,
    output logic         last
);
    assign last = (cnt == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clear)
            cnt <= '0;
        else if (en)
            cnt <= last ? '0 : cnt + W'(1);
    end
endmodule

// File: rtl/dbk_edge_sched.sv
module dbk_edge_sched
    import dbk_sched_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    parameter int WPB  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    output logic       busy,
    output logic       done,
    output logic       fetch_req,
    output logic [4:0] fetch_blk,
    output logic       sram_wr,
    output logic       xpose_shift,
    output logic       filt_en,
    output logic       filt_dir,
    output logic [1:0] src_sel,
    output logic [4:0] edge_num,
    output logic [4:0] blk_idx,
    output logic [1:0] word_idx,
    output logic       out_en,
    output logic [4:0] out_blk,
    output logic [7:0] cycle_cnt
);
    localparam int GRID  = COLS + 1;
    localparam int BW    = 5;
    localparam int EW    = 5;
    localparam int CYW   = 8;
    localparam int WI    = $clog2(WPB);
    localparam int PRE_W = COLS * WPB;
    localparam int CW    = $clog2(PRE_W);
    localparam int RW    = $clog2(ROWS);
    localparam int CLW   = $clog2(COLS);
    localparam int NEDGE = 2 * ROWS * COLS;

    sched_state_t  state;
    logic [RW-1:0] row;
    logic [CLW-1:0] col;
    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;
    logic          ph_last;
    logic          working;
    logic [BW-1:0] cur_blk, left_blk, next_left_blk, above_blk;

    assign working = (state != ST_IDLE) && (state != ST_DONE);
    assign limit   = (state == ST_PRELOAD || state == ST_FLUSH) ? CW'(PRE_W - 1) : CW'(WPB - 1);

    dbk_word_ctr #(.W(CW)) u_word_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state == ST_IDLE),
        .en    (working),
        .limit (limit),
        .cnt   (cnt),
        .last  (ph_last)
    );

    assign cur_blk       = BW'((int'(row) + 1) * GRID + int'(col) + 1);
    assign left_blk      = BW'((int'(row) + 1) * GRID);
    assign next_left_blk = BW'((int'(row) + 2) * GRID);
    assign above_blk     = BW'(int'(cur_blk) - GRID);

    // State register and sequencing counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            row       <= '0;
            col       <= '0;
            edge_num  <= '0;
            cycle_cnt <= '0;
        end else begin
            if (working)
                cycle_cnt <= cycle_cnt + CYW'(1);
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state     <= ST_PRELOAD;
                        row       <= '0;
                        col       <= '0;
                        edge_num  <= '0;
                        cycle_cnt <= '0;
                    end
                end
                ST_PRELOAD: if (ph_last) state <= ST_LEFT;
                ST_LEFT: begin
                    if (ph_last) begin
                        state <= ST_VEDGE;
                        col   <= '0;
                    end
                end
                ST_VEDGE: begin
                    if (ph_last) begin
                        edge_num <= edge_num + EW'(1);
                        if (col == '0)
                            col <= CLW'(1);
                        else begin
                            state <= ST_XPOSE;
                            col   <= col - CLW'(1);
                        end
                    end
                end
                ST_XPOSE: if (ph_last) state <= ST_HEDGE;
                ST_HEDGE: begin
                    if (ph_last) begin
                        if (edge_num != EW'(NEDGE - 1))
                            edge_num <= edge_num + EW'(1);
                        if (int'(col) < COLS - 2) begin
                            state <= ST_VEDGE;
                            col   <= col + CLW'(2);
                        end else if (int'(col) == COLS - 2) begin
                            state <= ST_XPOSE;
                            col   <= col + CLW'(1);
                        end else if (int'(row) == ROWS - 1) begin
                            state <= ST_FLUSH;
                        end else begin
                            state <= ST_VEDGE;
                            row   <= row + RW'(1);
                            col   <= '0;
                        end
                    end
                end
                ST_FLUSH: if (ph_last) state <= ST_DONE;
                ST_DONE:  state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Per-cycle control outputs
    always_comb begin
        busy        = (state != ST_IDLE);
        done        = (state == ST_DONE);
        fetch_req   = 1'b0;
        fetch_blk   = '0;
        sram_wr     = 1'b0;
        xpose_shift = 1'b0;
        filt_en     = 1'b0;
        filt_dir    = 1'b0;
        src_sel     = SRC_NONE;
        blk_idx     = '0;
        word_idx    = cnt[WI-1:0];
        out_en      = 1'b0;
        out_blk     = '0;
        unique case (state)
            ST_PRELOAD: begin
                fetch_req = 1'b1;
                sram_wr   = 1'b1;
                fetch_blk = BW'(cnt[CW-1:WI]) + BW'(1);
                blk_idx   = fetch_blk;
            end
            ST_LEFT: begin
                fetch_req = 1'b1;
                fetch_blk = left_blk;
                blk_idx   = left_blk;
            end
            ST_VEDGE: begin
                fetch_req = 1'b1;
                fetch_blk = cur_blk;
                filt_en   = 1'b1;
                src_sel   = SRC_SHIFT_IN;
                blk_idx   = cur_blk;
                if (col == '0) begin
                    out_en  = 1'b1;
                    out_blk = left_blk;
                end
            end
            ST_XPOSE: begin
                xpose_shift = 1'b1;
                blk_idx     = cur_blk;
                if (int'(col) == COLS - 1 && int'(row) != ROWS - 1) begin
                    fetch_req = 1'b1;
                    fetch_blk = next_left_blk;
                end
            end
            ST_HEDGE: begin
                filt_en  = 1'b1;
                filt_dir = 1'b1;
                src_sel  = SRC_SRAM_XP;
                sram_wr  = 1'b1;
                blk_idx  = cur_blk;
                out_en   = 1'b1;
                out_blk  = above_blk;
            end
            ST_FLUSH: begin
                out_en  = 1'b1;
                out_blk = BW'(ROWS * GRID) + BW'(cnt[CW-1:WI]) + BW'(1);
                blk_idx = out_blk;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dbk_edge_sched_chk.sv
module dbk_edge_sched_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic       fetch_req,
    input logic [4:0] fetch_blk,
    input logic       sram_wr,
    input logic       xpose_shift,
    input logic       filt_en,
    input logic       filt_dir,
    input logic [1:0] src_sel,
    input logic [4:0] edge_num,
    input logic [4:0] blk_idx,
    input logic [1:0] word_idx,
    input logic       out_en,
    input logic [4:0] out_blk,
    input logic [7:0] cycle_cnt
);
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // start pulses while busy must not restart the count
    assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (cycle_cnt == 8'($past(cycle_cnt) + 8'd1)));

    assert_vert_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_en && !filt_dir) |-> (src_sel == 2'd1 && fetch_req && !sram_wr));

    assert_horz_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_en && filt_dir) |-> (src_sel == 2'd2 && sram_wr && out_en && !fetch_req));

    assert_edge_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && edge_num != $past(edge_num))
            |-> (edge_num == 5'($past(edge_num) + 5'd1)));

    assert_overlap_left_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (xpose_shift && fetch_req) |-> (fetch_blk == 5'(blk_idx + 5'd1) && !filt_en));

    assert_filter_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        filt_en |-> (busy && !done));
endmodule

bind dbk_edge_sched dbk_edge_sched_chk u_chk (.*);

// File: tb/dbk_edge_sched_bench.sv
module dbk_edge_sched_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NEDGE = 32;
    localparam int TOTAL = 228;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       busy, done, fetch_req, sram_wr, xpose_shift, filt_en, filt_dir, out_en;
    logic [4:0] fetch_blk, edge_num, blk_idx, out_blk;
    logic [1:0] src_sel, word_idx;
    logic [7:0] cycle_cnt;

    int checks = 0;
    int errors = 0;
    int exp_blk [NEDGE];
    int exp_dir [NEDGE];

    always #(CLK_PERIOD/2) clk = ~clk;

    dbk_edge_sched u_dbk_edge_sched (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .fetch_req(fetch_req), .fetch_blk(fetch_blk), .sram_wr(sram_wr),
        .xpose_shift(xpose_shift), .filt_en(filt_en), .filt_dir(filt_dir),
        .src_sel(src_sel), .edge_num(edge_num), .blk_idx(blk_idx),
        .word_idx(word_idx), .out_en(out_en), .out_blk(out_blk),
        .cycle_cnt(cycle_cnt)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference order: vertical edge of column c, then the top edge of column c-1
    task automatic build_ref();
        int k = 0;
        for (int r = 0; r < 4; r++) begin
            for (int c = 0; c < 4; c++) begin
                exp_blk[k] = (r + 1) * 5 + c + 1; exp_dir[k] = 0; k++;
                if (c >= 1) begin
                    exp_blk[k] = (r + 1) * 5 + c; exp_dir[k] = 1; k++;
                end
            end
            exp_blk[k] = (r + 1) * 5 + 4; exp_dir[k] = 1; k++;
        end
    endtask

    // Run one macroblock; poke=1 adds start pulses while busy
    task automatic run_mb(input bit poke);
        int ecount = 0, bad_edge = 0, filt_cyc = 0, xp_cyc = 0, ovl_cyc = 0;
        int ovl_bad = 0, left_out = 0, left_bad = 0, done_cnt = 0, done_n = 0;
        int pre_bad = 0, l0_bad = 0, fl_bad = 0, xp_order_bad = 0, xp_idx = 0;
        int last_edge = -1;
        @(negedge clk);
        start = 1'b1;
        for (int n = 1; n <= 240; n++) begin
            @(negedge clk);
            start = (poke && (n == 60 || n == 150 || n == 213)) ? 1'b1 : 1'b0;
            if (n <= 16) begin
                if (!(fetch_req && sram_wr && fetch_blk == 5'(1 + (n - 1) / 4)
                      && word_idx == 2'((n - 1) % 4))) pre_bad++;
            end else if (n <= 20) begin
                if (!(fetch_req && fetch_blk == 5'd5 && !filt_en)) l0_bad++;
            end
            if (filt_en) filt_cyc++;
            if (filt_en && word_idx == 2'd0) begin
                if (ecount < NEDGE) begin
                    if (edge_num != 5'(ecount) || blk_idx != 5'(exp_blk[ecount])
                        || filt_dir != exp_dir[ecount][0]
                        || src_sel != (exp_dir[ecount] == 1 ? 2'd2 : 2'd1)
                        || (exp_dir[ecount] == 1 && out_blk != 5'(exp_blk[ecount] - 5)))
                        bad_edge++;
                    last_edge = int'(edge_num);
                end
                ecount++;
            end
            if (xpose_shift) begin
                xp_cyc++;
                if (word_idx == 2'd0) begin
                    if (blk_idx != 5'((xp_idx / 4 + 1) * 5 + xp_idx % 4 + 1)) xp_order_bad++;
                    xp_idx++;
                end
                if (fetch_req) begin
                    ovl_cyc++;
                    if (fetch_blk != 5'((ovl_cyc - 1) / 4 * 5 + 10)) ovl_bad++;
                end
            end
            if (filt_en && !filt_dir && out_en) begin
                left_out++;
                if (out_blk != 5'((left_out - 1) / 4 * 5 + 5)) left_bad++;
            end
            if (n >= 213 && n <= 228) begin
                if (!(out_en && !filt_en && out_blk == 5'(21 + (n - 213) / 4))) fl_bad++;
            end
            if (done) begin
                done_cnt++;
                done_n = n;
                chk(cycle_cnt == 8'(TOTAL), "R8 cycle_cnt at done", int'(cycle_cnt), TOTAL);
            end
            if (n == 231) break;
        end
        start = 1'b0;
        chk(pre_bad == 0, "R2 preload words", pre_bad, 0);
        chk(l0_bad == 0, "R3 first left fetch", l0_bad, 0);
        chk(ecount == NEDGE, "R4 edge count", ecount, NEDGE);
        chk(bad_edge == 0, "R4 edge order/block", bad_edge, 0);
        chk(filt_cyc == NEDGE * 4, "R5 filter cycles", filt_cyc, NEDGE * 4);
        chk(xp_cyc == 64 && xp_order_bad == 0, "R6 transpose cycles", xp_cyc, 64);
        chk(ovl_cyc == 12 && ovl_bad == 0, "R6 overlap fetch", ovl_cyc, 12);
        chk(fl_bad == 0, "R7 flush blocks", fl_bad, 0);
        chk(done_cnt == 1, "R8 done pulses", done_cnt, 1);
        chk(done_n == TOTAL + 1, "R8 done cycle", done_n, TOTAL + 1);
        chk(last_edge == NEDGE - 1, "R10 last edge number", last_edge, NEDGE - 1);
        chk(left_out == 16 && left_bad == 0, "R11 left neighbour out", left_out, 16);
        chk(!busy, "R9 idle after run", int'(busy), 0);
    endtask

    task automatic t_reset();
        chk(!busy && !done, "R1 busy/done", int'({busy, done}), 0);
        chk(!fetch_req && !sram_wr && !xpose_shift, "R1 fetch/wr/xpose",
            int'({fetch_req, sram_wr, xpose_shift}), 0);
        chk(!filt_en && !out_en, "R1 filt/out", int'({filt_en, out_en}), 0);
    endtask

    task automatic t_plain_run();
        run_mb(1'b0);
    endtask

    task automatic t_start_while_busy();
        run_mb(1'b1);
    endtask

    task automatic t_idle_hold();
        repeat (5) @(negedge clk);
        chk(!busy && !fetch_req && !filt_en, "R9 stays idle without start",
            int'({busy, fetch_req, filt_en}), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        build_ref();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain_run();
        t_idle_hold();
        t_start_while_busy();
        t_plain_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule